// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a synchronous internal bus, which issues one request at a time, read and write an external asynchronous static RAM of 256K bytes. The RAM has an 18-bit address, a shared 8-bit data bus, two chip selects of opposite polarity, a write strobe and an output enable. The controller latches each accepted request and plays it out as a read or write cycle on the RAM pins. Each phase of that cycle lasts a whole number of system clock cycles, derived at elaboration time from nanosecond timing parameters and a clock-period parameter.

Read data comes back on a registered output together with a one-cycle done pulse. A write also ends with a done pulse. The block does not build the pad tri-state buffer. It provides a drive-enable output and separate outgoing and incoming data buses. A low-power retention request pulls the active-high select low. When the request drops, the controller waits one read cycle time before it accepts new work.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `reqReady` is 1, `memCsN` is 1, `memCs` is 1, `memWeN` is 1, `memOeN` is 1 and `memDrive` is 0.
- R2: A read holds `memCsN`=0, `memCs`=1, `memWeN`=1 and `memOeN`=0. It samples `memDin` at the end of that window and returns the byte on `rspRdata`. At the same time `rspValid` is 1 for exactly one cycle.
- R3: `memWeN` is 0 only while `memCsN`=0, `memCs`=1, `memOeN`=1 and `memDrive`=1. The drive stays on for one cycle after `memWeN` rises. The address does not change while the RAM is selected.
- R4: A write ends with a one-cycle `rspValid`. A later read of the same address returns the written byte.
- R5: `memDrive` is never 1 while `memOeN` is 0. After `memOeN` rises, the controller does not drive for at least ceil(T_OHZ_NS/CLK_PERIOD_NS) cycles.
- R6: A request is taken only in a cycle where `reqValid` and `reqReady` are both 1. Requests presented while `reqReady` is 0 leave the memory unchanged.
- R7: `reqReady` is 0 from the cycle after a request is accepted until that operation has finished.
- R8: While `sleepReq` is 1, `memCs` is 0, `memCsN` is 1, `memWeN` is 1, `memOeN` is 1, `memDrive` is 0 and `reqReady` is 0.
- R9: After `sleepReq` falls, `memCs` returns to 1. `reqReady` stays 0 for exactly ceil(T_RC_NS/CLK_PERIOD_NS) cycles.
- R10: Each count is max(1, ceil(ns/CLK_PERIOD_NS)). The low time of `memWeN` is max(ceil(T_WP), ceil(T_DW), ceil(T_AW)-1) cycles, the -1 accounting for the one setup cycle. The low time of `memOeN` in a read is max(ceil(T_AA), ceil(T_OE))+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Request byte address |
| reqWdata | input | 8 | Write byte |
| sleepReq | input | 1 | Enter low-power retention while high |
| reqReady | output | 1 | Controller idle and able to accept |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Read byte, valid with rspValid after a read |
| memAddr | output | 18 | RAM address |
| memCsN | output | 1 | Active-low chip select |
| memCs | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memDout | output | 8 | Data toward the RAM |
| memDrive | output | 1 | Enables the pad driver for memDout |
| memDin | input | 8 | Data from the RAM pads |

## Verification
The main function is exercised by a table of writes and reads. The addresses sit at the bottom, top and middle of the address space, and the data includes all-ones and all-zeros. One address is overwritten and then read back, which separates a write that reaches the memory from one that is ignored. Read-after-write and write-after-read pairs appear back to back. The RAM model returns a garbage byte until its access time has elapsed, so a shortened read window shows up as wrong data, and it rejects a write pulse that is too short. The exact widths of the write strobe and the read enable are measured cycle by cycle. A request held through a busy operation and a write attempted during retention confirm that only accepted requests reach the memory. Retention is then checked for the select levels and for the exact recovery delay.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_READ_ACCESS,
    ST_READ_CAPTURE,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_WRITE_HOLD,
    ST_BUS_TURNAROUND,
    ST_SLEEP,
    ST_WAKE
  } ctrlState_e;

  // Strobes from control to datapath, all active high.
  typedef struct packed {
    logic selActive;   // both chip selects asserted
    logic retain;      // active-high select pulled low
    logic outEnable;   // RAM output enable asserted
    logic writeStrobe; // write enable asserted
    logic busDrive;    // controller drives the data bus
    logic loadReq;     // latch address and write data
    logic captureRd;   // sample read data this edge
    logic opDone;      // operation finishes this cycle
  } pinStrobe_t;

  // Rounds a time up to whole clock cycles, never below one.
  function automatic int unsigned nsToCycles(input int unsigned ns,
                                             input int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_AA_NS       = 85,
  parameter int unsigned T_OE_NS       = 45,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AW_NS       = 75,
  parameter int unsigned T_DW_NS       = 35,
  parameter int unsigned T_OHZ_NS      = 35,
  parameter int unsigned T_RC_NS       = 85
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       sleepReq,
  output logic       reqReady,
  output pinStrobe_t strobe
);

  localparam int unsigned RD_CYC = maxOf(nsToCycles(T_AA_NS, CLK_PERIOD_NS),
                                         nsToCycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned AW_CYC = nsToCycles(T_AW_NS, CLK_PERIOD_NS);
  localparam int unsigned AW_PULSE = (AW_CYC > 1) ? AW_CYC - 1 : 1;
  localparam int unsigned WP_CYC = maxOf(maxOf(nsToCycles(T_WP_NS, CLK_PERIOD_NS),
                                               nsToCycles(T_DW_NS, CLK_PERIOD_NS)),
                                         AW_PULSE);
  localparam int unsigned TA_CYC = nsToCycles(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned RC_CYC = nsToCycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(TA_CYC, RC_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  ctrlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic cntZero;
  logic accept;

  assign cntZero  = (cntQ == '0);
  assign reqReady = (stateQ == ST_IDLE) && !sleepReq;
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateD = stateQ;
    cntD   = cntZero ? cntQ : cntQ - 1'b1;
    unique case (stateQ)
      ST_IDLE: begin
        if (sleepReq) begin
          stateD = ST_SLEEP;
        end else if (reqValid) begin
          if (reqWrite) begin
            stateD = ST_WRITE_SETUP;
          end else begin
            stateD = ST_READ_ACCESS;
            cntD   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ_ACCESS:  if (cntZero) stateD = ST_READ_CAPTURE;
      ST_READ_CAPTURE: begin
        stateD = ST_BUS_TURNAROUND;
        cntD   = CNT_W'(TA_CYC - 1);
      end
      ST_BUS_TURNAROUND: if (cntZero) stateD = ST_IDLE;
      ST_WRITE_SETUP: begin
        stateD = ST_WRITE_PULSE;
        cntD   = CNT_W'(WP_CYC - 1);
      end
      ST_WRITE_PULSE: if (cntZero) stateD = ST_WRITE_HOLD;
      ST_WRITE_HOLD:  stateD = ST_IDLE;
      ST_SLEEP: begin
        if (!sleepReq) begin
          stateD = ST_WAKE;
          cntD   = CNT_W'(RC_CYC - 1);
        end
      end
      ST_WAKE: if (cntZero) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.loadReq     = accept;
    strobe.retain      = (stateQ == ST_SLEEP);
    strobe.selActive   = (stateQ == ST_READ_ACCESS) || (stateQ == ST_READ_CAPTURE) ||
                         (stateQ == ST_WRITE_SETUP) || (stateQ == ST_WRITE_PULSE) ||
                         (stateQ == ST_WRITE_HOLD);
    strobe.outEnable   = (stateQ == ST_READ_ACCESS) || (stateQ == ST_READ_CAPTURE);
    strobe.writeStrobe = (stateQ == ST_WRITE_PULSE);
    strobe.busDrive    = (stateQ == ST_WRITE_SETUP) || (stateQ == ST_WRITE_PULSE) ||
                         (stateQ == ST_WRITE_HOLD);
    strobe.captureRd   = (stateQ == ST_READ_CAPTURE);
    strobe.opDone      = (stateQ == ST_READ_CAPTURE) || (stateQ == ST_WRITE_HOLD);
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.captureRd) rdataQ <= memDin;
      doneQ <= strobe.opDone;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign memCsN   = !strobe.selActive;
  assign memCs    = !strobe.retain;
  assign memWeN   = !strobe.writeStrobe;
  assign memOeN   = !strobe.outEnable;
  assign memDrive = strobe.busDrive;
  assign rspValid = doneQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_AA_NS       = 85,
  parameter int unsigned T_OE_NS       = 45,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AW_NS       = 75,
  parameter int unsigned T_DW_NS       = 35,
  parameter int unsigned T_OHZ_NS      = 35,
  parameter int unsigned T_RC_NS       = 85
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              sleepReq,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive,
  input  logic [DATA_W-1:0] memDin
);

  pinStrobe_t strobe;

  asram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS),
    .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS),
    .T_DW_NS(T_DW_NS),
    .T_OHZ_NS(T_OHZ_NS),
    .T_RC_NS(T_RC_NS)
  ) ctrlI (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .sleepReq(sleepReq),
    .reqReady(reqReady),
    .strobe(strobe)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dpI (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .memDin(memDin),
    .rspValid(rspValid),
    .rspRdata(rspRdata),
    .memAddr(memAddr),
    .memCsN(memCsN),
    .memCs(memCs),
    .memWeN(memWeN),
    .memOeN(memOeN),
    .memDout(memDout),
    .memDrive(memDrive)
  );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memCs,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDrive
);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memCs && memWeN && memOeN && !memDrive));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R3
  write_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memCs && memOeN && memDrive));

  // R3
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDrive);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> memOeN);

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |=> !memDrive);

  // R8
  retention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCs |-> (memCsN && !reqReady && !memDrive && memWeN));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W)) chkI (
  .clk(clk),
  .rstN(rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memAddr(memAddr),
  .memCsN(memCsN),
  .memCs(memCs),
  .memWeN(memWeN),
  .memOeN(memOeN),
  .memDrive(memDrive)
);

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

  localparam int PERIOD = 4;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_WE_LOW = mx(mx(cyc(55), cyc(35)), cyc(75) - 1);
  localparam int EXP_OE_LOW = mx(cyc(85), cyc(45)) + 1;
  localparam int EXP_WAKE   = cyc(85);
  localparam int MODEL_AA   = cyc(85);
  localparam int MODEL_WP   = cyc(55);
  localparam int MODEL_OHZ  = cyc(35);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, sleepReq = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid, memCsN, memCs, memWeN, memOeN, memDrive;
  logic [7:0] rspRdata, memDout, memDin;
  logic [17:0] memAddr;

  always #(PERIOD / 2) clk = ~clk;

  async_sram_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .sleepReq(sleepReq),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .memAddr(memAddr), .memCsN(memCsN), .memCs(memCs), .memWeN(memWeN),
    .memOeN(memOeN), .memDout(memDout), .memDrive(memDrive), .memDin(memDin)
  );

  // Behavioural RAM: 64 bytes indexed by the low address bits.
  logic [7:0] modelMem [64];
  int rdCnt, weCnt, oeHigh, violations;
  logic rdAct, wrAct;
  assign rdAct = !memCsN && memCs && memWeN && !memOeN;
  assign wrAct = !memCsN && memCs && !memWeN;
  assign memDin = (rdAct && rdCnt >= MODEL_AA) ? modelMem[memAddr[5:0]] : 8'hEE;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) modelMem[i] <= 8'h00;
      rdCnt <= 0; weCnt <= 0; oeHigh <= 100; violations <= 0;
    end else begin
      rdCnt <= rdAct ? rdCnt + 1 : 0;
      oeHigh <= memOeN ? oeHigh + 1 : 0;
      if (memDrive && (!memOeN || oeHigh < MODEL_OHZ)) violations <= violations + 1;
      if (wrAct) begin
        weCnt <= weCnt + 1;
        if (!memDrive) violations <= violations + 1;
      end else if (weCnt != 0) begin
        weCnt <= 0;
        if (weCnt >= MODEL_WP && memDrive) modelMem[memAddr[5:0]] <= memDout;
        else violations <= violations + 1;
      end
    end
  end

  // Run-length meters for the strobes.
  int weRun, oeRun, lastWeRun, lastOeRun;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weRun <= 0; oeRun <= 0; lastWeRun <= 0; lastOeRun <= 0;
    end else begin
      if (!memWeN) weRun <= weRun + 1;
      else if (weRun != 0) begin lastWeRun <= weRun; weRun <= 0; end
      if (!memOeN) oeRun <= oeRun + 1;
      else if (oeRun != 0) begin lastOeRun <= oeRun; oeRun <= 0; end
    end
  end

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit busyLow;
  task automatic doOp(input bit wr, input logic [17:0] a, input logic [7:0] d,
                      output logic [7:0] q, output bit ok);
    int n;
    n = 0;
    while (!reqReady && n < 1000) begin @(negedge clk); n++; end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    busyLow = !reqReady;
    n = 0;
    while (!rspValid && n < 1000) begin @(negedge clk); n++; end
    q = rspRdata;
    ok = rspValid;
  endtask

  // {write, address, write data, expected read data}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 18'h00005, 8'hA5, 8'h00},
    {1'b1, 18'h3FFC1, 8'h3C, 8'h00},
    {1'b1, 18'h20012, 8'hFF, 8'h00},
    {1'b0, 18'h00005, 8'h00, 8'hA5},
    {1'b0, 18'h3FFC1, 8'h00, 8'h3C},
    {1'b1, 18'h00005, 8'h00, 8'h00},
    {1'b0, 18'h00005, 8'h00, 8'h00},
    {1'b0, 18'h20012, 8'h00, 8'hFF}
  };

  initial begin
    #(PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    bit ok;
    int k;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset/idle pin levels
    check(reqReady && memCsN && memCs && memWeN && memOeN && !memDrive, "R1",
          {reqReady, memCsN, memCs, memWeN, memOeN, memDrive}, 6'b111110);

    for (int i = 0; i < 8; i++) begin
      logic wr; logic [17:0] a; logic [7:0] d, e;
      {wr, a, d, e} = VEC[i];
      doOp(wr, a, d, q, ok);
      check(busyLow, "R7", busyLow, 1);
      if (wr) begin
        check(ok, "R4", ok, 1);
        check(lastWeRun == EXP_WE_LOW, "R10 write strobe", lastWeRun, EXP_WE_LOW);
      end else begin
        check(ok && q == e, "R2/R4 readback", q, e);
        @(negedge clk);
        check(lastOeRun == EXP_OE_LOW, "R10 read enable", lastOeRun, EXP_OE_LOW);
      end
    end

    // R6: request held through a busy write is not taken.
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00030; reqWdata = 8'h11;
    @(negedge clk);
    reqAddr = 18'h00021; reqWdata = 8'h77;
    k = 0;
    while (!reqReady && k < 1000) begin @(negedge clk); k++; end
    reqValid = 1'b0;
    doOp(1'b0, 18'h00021, 8'h00, q, ok);
    check(q == 8'h00, "R6 ignored request", q, 8'h00);
    doOp(1'b0, 18'h00030, 8'h00, q, ok);
    check(q == 8'h11, "R6 accepted request", q, 8'h11);

    // R8 retention and R9 recovery.
    while (!reqReady) @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    check(!memCs && memCsN && memWeN && memOeN && !memDrive && !reqReady, "R8",
          {memCs, memCsN, memWeN, memOeN, memDrive, reqReady}, 6'b011100);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00005; reqWdata = 8'h99;
    repeat (4) @(negedge clk);
    check(!memCs && !reqReady, "R8 held", {memCs, reqReady}, 2'b00);
    reqValid = 1'b0;
    sleepReq = 1'b0;
    @(negedge clk);
    check(memCs, "R9 select restored", memCs, 1);
    k = 1;
    while (!reqReady && k < 1000) begin @(negedge clk); k++; end
    check(k - 1 == EXP_WAKE, "R9 recovery cycles", k - 1, EXP_WAKE);
    doOp(1'b0, 18'h20012, 8'h00, q, ok);
    check(q == 8'hFF, "R8 data retained", q, 8'hFF);
    doOp(1'b0, 18'h00005, 8'h00, q, ok);
    check(q == 8'h00, "R6 write during sleep ignored", q, 8'h00);

    repeat (2) @(negedge clk);
    check(violations == 0, "R5/R3 bus protocol", violations, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule